// File: doc/BRIEF.md
# Four-Way Write-Back Cache Controller

This block sits between a processor load/store port and a word-wide main-memory port. It holds one data word per line, organised as a number of sets with four ways each. A request picks its set from the address bits just above the byte offset, and the stored tags of every way in that set are compared with the request tag at the same time. A valid match returns or updates the word in one cycle without touching memory. A miss stalls the processor while the controller picks a victim way and fetches the missing word.

Stores never go straight to memory. A store that hits changes only the line and marks it dirty. A store that misses first brings the word into the cache and then applies the store to it. A victim that is dirty is written out to memory before the fill read. A clean victim is simply overwritten. The victim policy is chosen at run time from three options: pseudo-random, least recently used, and first-in first-out. An empty way in the set always takes priority over the policy.

Top module: `wbcache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1 and `mem_req` is 0, so the first access to any address misses and reads memory.
- R2: A read whose tag matches a valid way in its set finishes in the cycle after acceptance (`cpu_done` high), returns the stored word and issues no memory transaction. At most one way of a set ever matches.
- R3: A write hit replaces the stored word and marks the line dirty without any memory write. The new word reaches memory only when that line is later evicted.
- R4: A write miss reads the addressed word from memory, installs it, then applies the write, leaving the line dirty. A read miss leaves the filled line clean.
- R5: A miss whose victim is clean issues exactly one memory read, at address {request tag, set, byte offset 0}, and holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`.
- R6: A miss whose victim is dirty issues a memory write of the victim word at {victim tag, set, 0}, followed by the read of the missing word: two transactions in that order.
- R7: While a set has an invalid way, a miss fills the lowest-numbered invalid way, whatever the policy.
- R8: With `repl_mode` = 2'b01 (LRU; 2'b11 behaves the same), the victim in a full set is the way least recently hit or filled.
- R9: With `repl_mode` = 2'b10 (FIFO), the victim in a full set is the way filled earliest; hits do not change the order.
- R10: With `repl_mode` = 2'b00 (random), the victim comes from a free-running LFSR. Every read still returns the last value written to that address, and a miss makes at most one write and one read.
- R11: `cpu_ready` is 1 only while the controller is idle. It drops in the cycle after a request is accepted and returns in the cycle after `cpu_done`.
- R12: The set is address bits [OFF_W+IDX_W-1:OFF_W], which is the word address modulo the number of sets. Addresses that differ only in tag share a set and can be held in different ways at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| repl_mode | input | 2 | Victim policy: 00 random, 01 LRU, 10 FIFO, 11 LRU |
| cpu_req | input | 1 | Request strobe, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse; `cpu_rdata` is valid with it |
| cpu_rdata | output | DATA_W | Load result |
| mem_req | output | 1 | Memory transaction request, held until `mem_ack` |
| mem_we | output | 1 | 1 for a write-back, 0 for a fill read |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | DATA_W | Fill data, valid with `mem_ack` |

## Verification
The bench builds the controller with four sets of four ways and a 10-bit address, which gives a 6-bit tag. With a few hundred accesses over six tags per set, every set fills, overflows and evicts many times. Dirty and clean victims both occur in LRU, FIFO and random modes. A bench-side model of tags, ages and FIFO pointers predicts each hit or miss and the exact write-back address and data. A shadow memory checks every returned word, including in random mode, where the victim cannot be predicted.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAGCHK,
    ST_WBACK,
    ST_FILL,
    ST_RESP
  } ctl_state_t;

  localparam logic [1:0] POL_RAND = 2'b00;
  localparam logic [1:0] POL_LRU  = 2'b01;
  localparam logic [1:0] POL_FIFO = 2'b10;

  localparam int          LFSR_W    = 16;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  // Fibonacci LFSR with taps at bits 16,14,13,11: maximal length
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/wbc_tag_match.sv
module wbc_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tag_row,
  input  logic [WAYS-1:0]            valid_row,
  input  logic [TAG_W-1:0]           ref_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit_any,
  output logic [WAY_W-1:0]           hit_way
);

  // one comparator per way, all evaluated in parallel
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_row[w] && (tag_row[w] == ref_tag);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/wbc_repl.sv
module wbc_repl
  import wbc_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 256,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] look_set,
  input  logic [WAYS-1:0]  valid_row,
  input  logic             touch_en,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);

  // age 0 = most recently used, WAYS-1 = least recently used
  logic [WAY_W-1:0]  age_q  [SETS][WAYS];
  logic [WAY_W-1:0]  fifo_q [SETS];
  logic [LFSR_W-1:0] lfsr_q;
  logic [WAY_W-1:0]  lru_way;
  logic [WAY_W-1:0]  pol_way;
  logic [WAY_W-1:0]  touched_age;

  assign touched_age = age_q[touch_set][touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
        fifo_q[s] <= '0;
      end
      lfsr_q <= LFSR_SEED;
    end else begin
      lfsr_q <= lfsr_step(lfsr_q);
      if (touch_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way)
            age_q[touch_set][w] <= '0;
          else if (age_q[touch_set][w] < touched_age)
            age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
        end
      end
      if (fill_en) fifo_q[touch_set] <= fifo_q[touch_set] + 1'b1;
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[look_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
    end
    case (mode)
      POL_RAND: pol_way = lfsr_q[WAY_W-1:0];
      POL_FIFO: pol_way = fifo_q[look_set];
      default:  pol_way = lru_way;
    endcase
    // an empty way always wins, lowest index first
    victim = pol_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_row[w]) victim = WAY_W'(w);
    end
  end

endmodule

// File: rtl/wbcache_ctrl.sv
module wbcache_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        repl_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  // ---------------- address arithmetic ----------------
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  // ---------------- storage ----------------
  logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
  logic [DATA_W-1:0] data_mem [SETS][WAYS];
  logic [WAYS-1:0]   valid_q  [SETS];
  logic [WAYS-1:0]   dirty_q  [SETS];

  // ---------------- request and control registers ----------------
  ctl_state_t        st_q, st_d;
  logic              rq_we;
  logic [TAG_W-1:0]  rq_tag;
  logic [IDX_W-1:0]  rq_idx;
  logic [DATA_W-1:0] rq_wdata;
  logic [WAY_W-1:0]  vic_q;
  logic [DATA_W-1:0] resp_q;

  // ---------------- named internal events ----------------
  logic [WAYS-1:0][TAG_W-1:0] tag_row;
  logic [WAYS-1:0]            valid_row;
  logic [WAYS-1:0]            hit_vec;
  logic                       hit_any;
  logic [WAY_W-1:0]           hit_way;
  logic [WAY_W-1:0]           victim;
  logic                       lookup;
  logic                       hit_ev;
  logic                       miss_ev;
  logic                       victim_dirty;
  logic                       wb_done;
  logic                       fill_done;
  logic                       touch_en;
  logic [WAY_W-1:0]           touch_way;
  logic                       unused_off;

  assign unused_off = ^cpu_addr[OFF_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign tag_row[w]   = tag_mem[rq_idx][w];
    assign valid_row[w] = valid_q[rq_idx][w];
  end

  wbc_tag_match #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W)
  ) u_match (
    .tag_row   (tag_row),
    .valid_row (valid_row),
    .ref_tag   (rq_tag),
    .hit_vec   (hit_vec),
    .hit_any   (hit_any),
    .hit_way   (hit_way)
  );

  assign lookup       = (st_q == ST_TAGCHK);
  assign hit_ev       = lookup && hit_any;
  assign miss_ev      = lookup && !hit_any;
  assign victim_dirty = valid_q[rq_idx][victim] && dirty_q[rq_idx][victim];
  assign wb_done      = (st_q == ST_WBACK) && mem_ack;
  assign fill_done    = (st_q == ST_FILL) && mem_ack;
  assign touch_en     = hit_ev || fill_done;
  assign touch_way    = hit_ev ? hit_way : vic_q;

  wbc_repl #(
    .WAYS (WAYS),
    .SETS (SETS)
  ) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (repl_mode),
    .look_set  (rq_idx),
    .valid_row (valid_row),
    .touch_en  (touch_en),
    .fill_en   (fill_done),
    .touch_set (rq_idx),
    .touch_way (touch_way),
    .victim    (victim)
  );

  // ---------------- next state and outputs ----------------
  always_comb begin
    st_d      = st_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = line_addr(rq_tag, rq_idx);
    mem_wdata = data_mem[rq_idx][vic_q];
    cpu_done  = 1'b0;
    cpu_rdata = resp_q;
    case (st_q)
      ST_IDLE: begin
        if (cpu_req) st_d = ST_TAGCHK;
      end
      ST_TAGCHK: begin
        if (hit_any) begin
          cpu_done  = 1'b1;
          cpu_rdata = data_mem[rq_idx][hit_way];
          st_d      = ST_IDLE;
        end else begin
          st_d = victim_dirty ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = line_addr(tag_mem[rq_idx][vic_q], rq_idx);
        if (mem_ack) st_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) st_d = ST_RESP;
      end
      ST_RESP: begin
        cpu_done = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cpu_ready = (st_q == ST_IDLE);

  // ---------------- control and status registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rq_we    <= 1'b0;
      rq_tag   <= '0;
      rq_idx   <= '0;
      rq_wdata <= '0;
      vic_q    <= '0;
      resp_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && cpu_req) begin
        rq_we    <= cpu_we;
        rq_tag   <= addr_tag(cpu_addr);
        rq_idx   <= addr_set(cpu_addr);
        rq_wdata <= cpu_wdata;
      end
      if (miss_ev) vic_q <= victim;
      if (hit_ev && rq_we) dirty_q[rq_idx][hit_way] <= 1'b1;
      if (fill_done) begin
        valid_q[rq_idx][vic_q] <= 1'b1;
        dirty_q[rq_idx][vic_q] <= rq_we;
        resp_q <= rq_we ? rq_wdata : mem_rdata;
      end
    end
  end

  // ---------------- tag and data arrays (no reset) ----------------
  always_ff @(posedge clk) begin
    if (hit_ev && rq_we) data_mem[rq_idx][hit_way] <= rq_wdata;
    if (fill_done) begin
      tag_mem[rq_idx][vic_q]  <= rq_tag;
      data_mem[rq_idx][vic_q] <= rq_we ? rq_wdata : mem_rdata;
    end
  end

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WAYS-1:0]   hit_vec
);

  // R1: no memory traffic while idle
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);

  // R2: a set never holds two valid copies of one tag
  assert_unique_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R11: accepting a request takes the controller out of idle
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_req |=> !cpu_ready);

  // R11: completion returns the controller to idle
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> cpu_ready);

  // R5: a pending memory request stays steady until acknowledged
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  // R6: a finished write-back is followed by the fill read
  assert_wb_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

  // R4: a finished fill read completes the processor request next
  assert_fill_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> cpu_done);

endmodule

bind wbcache_ctrl wbc_checker #(
  .ADDR_W (ADDR_W),
  .WAYS   (WAYS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_ready (cpu_ready),
  .cpu_done  (cpu_done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .hit_vec   (hit_vec)
);

// File: tb/sim_wbcache_ctrl.sv
module sim_wbcache_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int NWAYS  = 4;
  localparam int NSETS  = 4;
  localparam int MWORDS = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        repl_mode = 2'b01;
  logic              cpu_req = 1'b0;
  logic              cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ready, cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wbcache_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WAYS   (NWAYS),
    .SETS   (NSETS),
    .OFF_W  (2)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .repl_mode (repl_mode),
    .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
    .cpu_wdata (cpu_wdata), .cpu_ready (cpu_ready), .cpu_done (cpu_done),
    .cpu_rdata (cpu_rdata), .mem_req (mem_req), .mem_we (mem_we),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_ack (mem_ack),
    .mem_rdata (mem_rdata)
  );

  int ntests = 0;
  int nfail  = 0;

  // memory image, processor-visible image, transaction log
  logic [DATA_W-1:0] bmem [MWORDS];
  logic [DATA_W-1:0] gold [MWORDS];
  int nrd, nwr, rd_addr, wb_addr;
  logic [DATA_W-1:0] wb_data;
  bit rd_after_wr;

  // bench model of cache state (LRU and FIFO modes)
  int  mtag [NSETS][NWAYS];
  bit  mval [NSETS][NWAYS];
  bit  mdir [NSETS][NWAYS];
  int  mage [NSETS][NWAYS];
  int  mfifo [NSETS];

  // outputs of one access
  logic [DATA_W-1:0] o_rdata;
  int  o_cyc;
  bit  o_ready_bad;
  int  lcg = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: acknowledges two cycles after a request appears
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (rst_n && mem_req) begin
        if (lat == 1) begin
          lat = 0;
          mem_ack = 1'b1;
          if (mem_we) begin
            bmem[mem_addr[ADDR_W-1:2]] = mem_wdata;
            nwr++;
            wb_addr = int'(mem_addr[ADDR_W-1:2]);
            wb_data = mem_wdata;
          end else begin
            mem_rdata = bmem[mem_addr[ADDR_W-1:2]];
            nrd++;
            rd_addr = int'(mem_addr[ADDR_W-1:2]);
            rd_after_wr = (nwr > 0);
          end
        end else lat++;
      end
    end
  end

  task automatic do_reset(input logic [1:0] mode);
    @(negedge clk);
    rst_n = 1'b0;
    repl_mode = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < MWORDS; i++) gold[i] = bmem[i];
    for (int s = 0; s < NSETS; s++) begin
      mfifo[s] = 0;
      for (int w = 0; w < NWAYS; w++) begin
        mval[s][w] = 0; mdir[s][w] = 0; mtag[s][w] = 0; mage[s][w] = w;
      end
    end
  endtask

  // one processor access; waits for completion
  task automatic acc(input bit we, input int waddr, input logic [DATA_W-1:0] wd);
    @(negedge clk);
    nrd = 0; nwr = 0; rd_after_wr = 0;
    cpu_req = 1'b1; cpu_we = we;
    cpu_addr = ADDR_W'(waddr * 4); cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    o_cyc = 1;
    o_ready_bad = 0;
    while (!cpu_done && o_cyc < 200) begin
      if (cpu_ready) o_ready_bad = 1;
      @(negedge clk);
      o_cyc++;
    end
    if (cpu_ready) o_ready_bad = 1;
    o_rdata = cpu_rdata;
    if (!cpu_done) chk(0, "R11", "no completion", 0, 1);
  endtask

  task automatic model_touch(input int s, input int w);
    for (int v = 0; v < NWAYS; v++)
      if (v != w && mage[s][v] < mage[s][w]) mage[s][v]++;
    mage[s][w] = 0;
  endtask

  // pm: 0 random (data only), 1 LRU, 2 FIFO
  task automatic step(input bit we, input int waddr, input logic [DATA_W-1:0] wd,
                      input int pm, output bit was_hit);
    int s, t, hw, v;
    bit exp_hit, exp_wb;
    int exp_wb_addr;
    logic [DATA_W-1:0] exp_wb_data;
    string pol;
    s = waddr % NSETS;
    t = waddr / NSETS;
    hw = -1; exp_hit = 0; exp_wb = 0; exp_wb_addr = 0; exp_wb_data = '0;
    pol = (pm == 1) ? "R8" : "R9";
    if (pm != 0) begin
      for (int w = 0; w < NWAYS; w++) if (mval[s][w] && mtag[s][w] == t) hw = w;
      if (hw >= 0) begin
        exp_hit = 1;
        if (we) mdir[s][hw] = 1;
        model_touch(s, hw);
      end else begin
        v = -1;
        for (int w = NWAYS - 1; w >= 0; w--) if (!mval[s][w]) v = w;
        if (v < 0) begin
          if (pm == 1) begin
            for (int w = 0; w < NWAYS; w++) if (mage[s][w] == NWAYS - 1) v = w;
          end else v = mfifo[s];
        end
        exp_wb = mval[s][v] && mdir[s][v];
        exp_wb_addr = mtag[s][v] * NSETS + s;
        exp_wb_data = gold[exp_wb_addr];
        mtag[s][v] = t; mval[s][v] = 1; mdir[s][v] = we;
        model_touch(s, v);
        mfifo[s] = (mfifo[s] + 1) % NWAYS;
      end
    end
    acc(we, waddr, wd);
    was_hit = (nrd == 0);
    chk(!o_ready_bad, "R11", "ready during busy", 32'(o_ready_bad), 0);
    if (!we) chk(o_rdata == gold[waddr], (pm == 0) ? "R10" : "R2", "read data",
                 o_rdata, gold[waddr]);
    if (pm == 0) begin
      chk(nrd <= 1 && nwr <= 1 && (nwr == 0 || rd_after_wr), "R10", "txn count",
          32'(nwr * 16 + nrd), 32'h11);
      if (nrd == 1) chk(rd_addr == waddr, "R10", "fill address", 32'(rd_addr), 32'(waddr));
    end else begin
      chk(was_hit == exp_hit, pol, "hit/miss", 32'(was_hit), 32'(exp_hit));
      if (exp_hit) begin
        chk(nwr == 0 && o_cyc == 1, we ? "R3" : "R2", "hit cost",
            32'(nwr * 256 + o_cyc), 32'h1);
      end else begin
        chk(nrd == 1 && rd_addr == waddr, we ? "R4" : "R5", "fill read",
            32'(rd_addr), 32'(waddr));
        chk(nwr == (exp_wb ? 1 : 0), "R6", "write-back count", 32'(nwr), 32'(exp_wb));
        if (exp_wb && nwr == 1) begin
          chk(wb_addr == exp_wb_addr, pol, "victim address", 32'(wb_addr), 32'(exp_wb_addr));
          chk(wb_data == exp_wb_data, "R3", "write-back data", wb_data, exp_wb_data);
          chk(rd_after_wr, "R6", "write before read", 32'(rd_after_wr), 1);
        end
      end
    end
    if (we) gold[waddr] = wd;
  endtask

  // fill every way of every set, then hit all of them
  task automatic sweep(input int pm);
    bit h;
    int misses, hits;
    misses = 0; hits = 0;
    for (int s = 0; s < NSETS; s++)
      for (int t = 0; t < NWAYS; t++) begin
        step(1'b0, t * NSETS + s, '0, pm, h);
        if (!h) misses++;
      end
    chk(misses == NSETS * NWAYS, "R1", "cold misses", 32'(misses), 32'(NSETS * NWAYS));
    for (int t = 0; t < NWAYS; t++)
      for (int s = 0; s < NSETS; s++) begin
        step(1'b0, t * NSETS + s, '0, pm, h);
        if (h) hits++;
      end
    chk(hits == NSETS * NWAYS, "R7", "invalid ways filled first", 32'(hits),
        32'(NSETS * NWAYS));
    chk(hits == NSETS * NWAYS, "R12", "tags share a set", 32'(hits), 32'(NSETS * NWAYS));
  endtask

  task automatic churn(input int pm, input int n);
    bit h;
    for (int i = 0; i < n; i++) begin
      int a;
      lcg = lcg * 1103515245 + 12345;
      a = ((lcg >>> 8) & 32'h7fff) % (6 * NSETS);
      step(lcg[20], a, DATA_W'(lcg ^ i), pm, h);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    bit h;
    for (int i = 0; i < MWORDS; i++) bmem[i] = 32'hA500_0000 + DATA_W'(i * 7);
    do_reset(2'b01);
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R1", "ready after reset", 32'(cpu_ready), 1);
    chk(mem_req == 1'b0, "R1", "mem idle after reset", 32'(mem_req), 0);

    // LRU phase, with a directed eviction order
    sweep(1);
    step(1'b0, 2 * NSETS + 1, '0, 1, h);
    step(1'b0, 0 * NSETS + 1, '0, 1, h);
    step(1'b1, 3 * NSETS + 1, 32'hDEAD_0001, 1, h);
    step(1'b0, 4 * NSETS + 1, '0, 1, h);
    step(1'b0, 5 * NSETS + 1, '0, 1, h);
    step(1'b0, 1 * NSETS + 1, '0, 1, h);
    churn(1, 300);

    // FIFO phase
    do_reset(2'b10);
    sweep(1 + 1);
    step(1'b1, 0 * NSETS + 2, 32'hBEEF_0002, 2, h);
    step(1'b0, 4 * NSETS + 2, '0, 2, h);
    step(1'b0, 5 * NSETS + 2, '0, 2, h);
    churn(2, 300);

    // random phase
    do_reset(2'b00);
    sweep(0);
    churn(0, 300);
    for (int a = 0; a < 6 * NSETS; a++) step(1'b0, a, '0, 0, h);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule